// File: doc/BRIEF.md
# Analog Output Update and Reference Load Controller

This block is the register front end for a small bank of analog output converters and a pair of reference converters. A host writes a code to a channel's setting register; the block then sends that code to the channel's converter over a serial link with its own chip select and a load strobe. A per-channel busy flag in the status word stays set from the write until the converter has latched the new value. The host is expected to poll that flag before it writes to the same channel again.

A second register loads one of two reference converters. A write to it with the start bit set begins a timed load of the positive or negative reference, selected by another bit. A single reference-busy flag covers the load. A control register enables or disables each channel and selects whether codes are unsigned or two's complement. One serial shifter serves all channels. A write that arrives while its channel is busy is held and sent once the transfer in progress has finished.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset the status word is 0, every chip select `dac_cs_n_o` is high, and `dac_sclk_o`, `dac_ld_o` and `ref_strobe_o` are low.
- R2: A write to byte address 0x38 + 2*ch (ch below NCH) on an enabled channel sends the DW-bit code MSB first. Bit n is valid on `dac_sdata_o` while `dac_sclk_o` is high. Only `dac_cs_n_o[ch]` is low during the transfer.
- R3: Status bit 4+ch rises in the cycle after the setting write and stays high for exactly 2*DW+2 cycles when the shifter is idle: 2*DW shift cycles, the latch cycle, and the take-over cycle. `dac_ld_o` pulses for one cycle, in the last of them.
- R4: A setting write to a channel that is busy does not disturb the transfer in progress. The most recent such write is sent afterwards. When several channels are waiting, the lowest channel index is sent first.
- R5: A control write (byte address 0x20) with bits [6:4] = 2+ch sets the enable of channel ch to bit 0. For example, 0x40 disables channel 2 and 0x41 enables it. Setting writes to a disabled channel are ignored: no busy flag and no transfer. All channels are enabled after reset.
- R6: A control write with bits [6:4] = 0 stores bit 1 as the signed-code mode. In that mode the code sent is the written code with its MSB inverted, applied at the time of the setting write.
- R7: A write to byte address 0x2C with bit 7 set starts a reference load. Status bit 1 is high for REF_CYCLES cycles, `ref_pos_o` takes bit 8 (1 = positive, 0 = negative), and `ref_strobe_o` is high in the last busy cycle. With bit 7 clear the write has no effect.
- R8: A reference write that arrives while a reference load is busy is ignored. It neither extends the load nor changes `ref_pos_o`.
- R9: Status bits 0, 2 and 3, and the channel bits at or above 4+NCH, are always 0. Writes to unmapped addresses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 16 | Write data |
| status_o | output | 16 | Busy flags: bit 1 reference, bit 4+ch channel ch |
| dac_cs_n_o | output | NCH | Active-low chip select per channel |
| dac_sclk_o | output | 1 | Serial clock |
| dac_sdata_o | output | 1 | Serial data, MSB first |
| dac_ld_o | output | 1 | One-cycle latch strobe ending a transfer |
| ref_pos_o | output | 1 | Polarity of the latest accepted reference load |
| ref_strobe_o | output | 1 | One-cycle pulse ending a reference load |

## Verification
The bench builds the block with four channels, 16-bit codes and an 8-cycle reference load. Four channels make the highest setting address (0x3E) and the highest channel busy bit (bit 7) reachable, and let three channels wait at once so the lowest-index-first order can be seen. With 16-bit codes the signed mode flips bit 15. The short reference load lets the bench overlap a second reference write with a load in progress.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
   localparam int BUS_W      = 16;
   localparam int ST_REF_BIT = 1;
   localparam int ST_CH_BASE = 4;
   localparam logic [7:0] OFS_CTRL  = 8'h20;
   localparam logic [7:0] OFS_REFLD = 8'h2C;
   localparam logic [7:0] OFS_SET0  = 8'h38;
   localparam int REF_GO_BIT  = 7;
   localparam int REF_POS_BIT = 8;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_SHIFT = 2'd1,
      SH_LATCH = 2'd2
   } sh_state_e;
endpackage

// File: rtl/dacu_reg_front.sv
module dacu_reg_front
   import dacu_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 16,
   parameter int AW  = 8,
   localparam int CHW = $clog2(NCH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [BUS_W-1:0]        wr_data,
   input  logic                    take_i,
   input  logic [CHW-1:0]          take_ch_i,
   output logic [NCH-1:0]          pend_valid_o,
   output logic [NCH-1:0][DW-1:0]  pend_code_o
);
   logic           ctrl_hit;
   logic [2:0]     ctrl_op;
   logic           sgn_q;
   logic [NCH-1:0] en_q;
   logic [DW-1:0]  code_in;

   assign ctrl_hit = wr_en && (wr_addr == AW'(OFS_CTRL));
   assign ctrl_op  = wr_data[6:4];
   assign code_in  = wr_data[DW-1:0] ^ {sgn_q, {(DW-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sgn_q <= 1'b0;
      end else if (ctrl_hit && ctrl_op == 3'd0) begin
         sgn_q <= wr_data[1];
      end
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic set_hit;
      logic addr_hit;

      assign addr_hit = wr_en && (wr_addr == AW'(OFS_SET0 + 8'(2 * ch)));
      assign set_hit  = addr_hit && en_q[ch];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[ch] <= 1'b1;
         end else if (ctrl_hit && ctrl_op == 3'(ch + 2)) begin
            en_q[ch] <= wr_data[0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_valid_o[ch] <= 1'b0;
            pend_code_o[ch]  <= '0;
         end else begin
            if (take_i && take_ch_i == CHW'(ch)) begin
               pend_valid_o[ch] <= 1'b0;
            end
            if (set_hit) begin
               pend_valid_o[ch] <= 1'b1;
               pend_code_o[ch]  <= code_in;
            end
         end
      end

      // R5
      ign_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (addr_hit && !en_q[ch] && !pend_valid_o[ch]) |=> !pend_valid_o[ch]);
   end
endmodule

// File: rtl/dacu_serial_shifter.sv
module dacu_serial_shifter
   import dacu_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 16,
   localparam int CHW = $clog2(NCH),
   localparam int CW  = $clog2(2 * DW)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          pend_valid_i,
   input  logic [NCH-1:0][DW-1:0]  pend_code_i,
   output logic                    take_o,
   output logic [CHW-1:0]          take_ch_o,
   output logic [NCH-1:0]          active_o,
   output logic [NCH-1:0]          cs_n_o,
   output logic                    sclk_o,
   output logic                    sdata_o,
   output logic                    ld_o
);
   localparam logic [CW-1:0] LAST_CNT = CW'(2 * DW - 1);

   sh_state_e      state_q;
   logic [CHW-1:0] cur_q;
   logic [DW-1:0]  sreg_q;
   logic [CW-1:0]  cnt_q;
   logic           pick_v;
   logic [CHW-1:0] pick_ch;

   always_comb begin
      pick_v  = |pend_valid_i;
      pick_ch = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend_valid_i[i]) pick_ch = CHW'(i);
      end
   end

   assign take_o    = (state_q == SH_IDLE) && pick_v;
   assign take_ch_o = pick_ch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         cur_q   <= '0;
         sreg_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SH_IDLE: begin
               if (pick_v) begin
                  state_q <= SH_SHIFT;
                  cur_q   <= pick_ch;
                  sreg_q  <= pend_code_i[pick_ch];
                  cnt_q   <= '0;
               end
            end
            SH_SHIFT: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q[0]) sreg_q <= sreg_q << 1;
               if (cnt_q == LAST_CNT) state_q <= SH_LATCH;
            end
            SH_LATCH: state_q <= SH_IDLE;
            default:  state_q <= SH_IDLE;
         endcase
      end
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_sel
      assign active_o[ch] = (state_q != SH_IDLE) && (cur_q == CHW'(ch));
      assign cs_n_o[ch]   = !active_o[ch];
   end

   assign sclk_o  = (state_q == SH_SHIFT) && cnt_q[0];
   assign sdata_o = (state_q == SH_SHIFT) && sreg_q[DW-1];
   assign ld_o    = (state_q == SH_LATCH);

   // R2
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n_o));

   // R4
   cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SH_SHIFT && $past(state_q) == SH_SHIFT) |-> $stable(cur_q));

   // R3
   ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_o |=> !ld_o);

   // R2
   sclk_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |=> !sclk_o);
endmodule

// File: rtl/dacu_ref_loader.sv
module dacu_ref_loader
   import dacu_pkg::*;
#(
   parameter int REF_CYCLES = 8,
   parameter int AW         = 8,
   localparam int RW        = $clog2(REF_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   output logic             busy_o,
   output logic             pos_o,
   output logic             strobe_o
);
   logic          start;
   logic [RW-1:0] cnt_q;

   assign start = wr_en && (wr_addr == AW'(OFS_REFLD)) &&
                  wr_data[REF_GO_BIT] && !busy_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         pos_o  <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_o <= 1'b1;
         pos_o  <= wr_data[REF_POS_BIT];
         cnt_q  <= RW'(REF_CYCLES - 1);
      end else if (busy_o) begin
         if (cnt_q == '0) busy_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign strobe_o = busy_o && (cnt_q == '0);

   // R7
   ref_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !busy_o);

   // R8
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !strobe_o) |=> (busy_o && $stable(pos_o)));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
   import dacu_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int DW         = 16,
   parameter int AW         = 8,
   parameter int REF_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [15:0]      wr_data,
   output logic [15:0]      status_o,
   output logic [NCH-1:0]   dac_cs_n_o,
   output logic             dac_sclk_o,
   output logic             dac_sdata_o,
   output logic             dac_ld_o,
   output logic             ref_pos_o,
   output logic             ref_strobe_o
);
   localparam int CHW = $clog2(NCH);

   if (NCH != 2 && NCH != 4) begin : g_bad_nch
      $error("NCH must be 2 or 4");
   end
   if (DW < 2 || DW > BUS_W) begin : g_bad_dw
      $error("DW must lie in 2..16");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (REF_CYCLES < 2) begin : g_bad_ref
      $error("REF_CYCLES must be at least 2");
   end

   logic [NCH-1:0]          pend_valid;
   logic [NCH-1:0][DW-1:0]  pend_code;
   logic                    take;
   logic [CHW-1:0]          take_ch;
   logic [NCH-1:0]          active;
   logic                    ref_busy;

   dacu_reg_front #(.NCH(NCH), .DW(DW), .AW(AW)) front_i (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .take_i(take), .take_ch_i(take_ch),
      .pend_valid_o(pend_valid), .pend_code_o(pend_code)
   );

   dacu_serial_shifter #(.NCH(NCH), .DW(DW)) shift_i (
      .clk, .rst_n,
      .pend_valid_i(pend_valid), .pend_code_i(pend_code),
      .take_o(take), .take_ch_o(take_ch), .active_o(active),
      .cs_n_o(dac_cs_n_o), .sclk_o(dac_sclk_o),
      .sdata_o(dac_sdata_o), .ld_o(dac_ld_o)
   );

   dacu_ref_loader #(.REF_CYCLES(REF_CYCLES), .AW(AW)) ref_i (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .busy_o(ref_busy), .pos_o(ref_pos_o), .strobe_o(ref_strobe_o)
   );

   always_comb begin
      status_o             = '0;
      status_o[ST_REF_BIT] = ref_busy;
      for (int ch = 0; ch < NCH; ch++) begin
         status_o[ST_CH_BASE + ch] = pend_valid[ch] | active[ch];
      end
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
      // R3
      busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !dac_cs_n_o[ch] |-> status_o[ST_CH_BASE + ch]);
   end
endmodule

// File: tb/dac_update_ctrl_tb_top.sv
module dac_update_ctrl_tb_top;
   localparam int NCH = 4;
   localparam int DW  = 16;
   localparam int AW  = 8;
   localparam int REFC = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [15:0]    wr_data = '0;
   logic [15:0]    status_o;
   logic [NCH-1:0] dac_cs_n_o;
   logic           dac_sclk_o, dac_sdata_o, dac_ld_o, ref_pos_o, ref_strobe_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [17:0] exp_q[$];
   int frames_seen = 0;
   int frames_exp  = 0;

   always #5 clk = ~clk;

   dac_update_ctrl #(.NCH(NCH), .DW(DW), .AW(AW), .REF_CYCLES(REFC)) dut_i (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .status_o, .dac_cs_n_o,
      .dac_sclk_o, .dac_sdata_o, .dac_ld_o, .ref_pos_o, .ref_strobe_o
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic push(input int ch, input logic [15:0] code);
      exp_q.push_back({2'(ch), code});
      frames_exp++;
   endtask

   task automatic meas(input int b, output int n);
      n = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (status_o[b]) n++;
         else break;
      end
   endtask

   task automatic meas_ref(output int n, output int sat);
      n = 0; sat = -1;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (status_o[1]) begin
            n++;
            if (ref_strobe_o) sat = n;
         end else break;
      end
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (status_o == 16'h0 && exp_q.size() == 0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   // scoreboard monitor
   logic [15:0] mon_sh = '0;
   int          mon_nb = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (dac_cs_n_o != '1 && dac_sclk_o) begin
            mon_sh = {mon_sh[14:0], dac_sdata_o};
            mon_nb++;
         end
         if (dac_ld_o) begin
            int ch;
            ch = -1;
            for (int i = 0; i < NCH; i++) if (!dac_cs_n_o[i]) ch = i;
            frames_seen++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected frame on channel", ch, -1);
            end else begin
               logic [17:0] e;
               e = exp_q.pop_front();
               chk(ch == int'(e[17:16]), "R4", "frame channel order", ch, int'(e[17:16]));
               chk(mon_sh == e[15:0], "R2", "serial code", int'(mon_sh), int'(e[15:0]));
               chk(mon_nb == DW, "R2", "bits per frame", mon_nb, DW);
            end
            mon_nb = 0;
         end
      end
   end

   initial begin
      for (int k = 0; k < 100000; k++) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n, sat;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(status_o == 16'h0, "R1", "status after reset", status_o, 0);
      chk(dac_cs_n_o == '1, "R1", "chip selects after reset", dac_cs_n_o, 4'hF);
      chk(!dac_sclk_o && !dac_ld_o && !ref_strobe_o, "R1", "strobes after reset",
          {dac_sclk_o, dac_ld_o, ref_strobe_o}, 0);

      // R3 busy duration, R2 frame on channel 0
      push(0, 16'hA5C3);
      wr(8'h38, 16'hA5C3);
      meas(4, n);
      chk(n == 2 * DW + 2, "R3", "busy cycles channel 0", n, 2 * DW + 2);
      wait_idle();

      // R2 channel 3, R9 only bit 7 set while busy
      push(3, 16'h1234);
      wr(8'h3E, 16'h1234);
      @(negedge clk);
      chk(status_o == 16'h0080, "R9", "status while channel 3 busy", status_o, 16'h0080);
      wait_idle();

      // R4 writes to busy channel: latest pending wins
      push(1, 16'h00FF);
      push(1, 16'h4321);
      wr(8'h3A, 16'h00FF);
      repeat (5) @(posedge clk);
      wr(8'h3A, 16'hBEEF);
      wr(8'h3A, 16'h4321);
      wait_idle();

      // R4 lowest index first among waiting channels
      push(0, 16'h1111);
      push(2, 16'h2222);
      push(3, 16'h3333);
      wr(8'h38, 16'h1111);
      wr(8'h3E, 16'h3333);
      wr(8'h3C, 16'h2222);
      wait_idle();

      // R5 disabled channel ignores writes
      wr(8'h20, 16'h0040);
      wr(8'h3C, 16'h5555);
      n = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (status_o[6]) n++;
      end
      chk(n == 0, "R5", "busy cycles on disabled channel 2", n, 0);
      chk(frames_seen == frames_exp, "R5", "frames after disabled write", frames_seen, frames_exp);
      wr(8'h20, 16'h0041);
      push(2, 16'h6666);
      wr(8'h3C, 16'h6666);
      wait_idle();

      // R6 signed mode flips MSB
      wr(8'h20, 16'h0002);
      push(1, 16'h8005);
      wr(8'h3A, 16'h0005);
      wait_idle();
      wr(8'h20, 16'h0000);
      push(1, 16'h0005);
      wr(8'h3A, 16'h0005);
      wait_idle();

      // R7 positive reference
      wr(8'h2C, 16'h0180);
      meas_ref(n, sat);
      chk(n == REFC, "R7", "ref busy cycles positive", n, REFC);
      chk(sat == REFC, "R7", "ref strobe position", sat, REFC);
      chk(ref_pos_o == 1'b1, "R7", "ref polarity positive", ref_pos_o, 1);
      // R7 negative reference
      wr(8'h2C, 16'h0080);
      meas_ref(n, sat);
      chk(n == REFC, "R7", "ref busy cycles negative", n, REFC);
      chk(ref_pos_o == 1'b0, "R7", "ref polarity negative", ref_pos_o, 0);
      // R7 start bit clear: no load
      wr(8'h2C, 16'h0100);
      meas_ref(n, sat);
      chk(n == 0, "R7", "ref busy without start bit", n, 0);
      chk(ref_pos_o == 1'b0, "R7", "ref polarity unchanged", ref_pos_o, 0);

      // R8 second ref write during load ignored
      wr(8'h2C, 16'h0180);
      fork
         meas_ref(n, sat);
         begin
            repeat (2) @(posedge clk);
            wr(8'h2C, 16'h0080);
         end
      join
      chk(n == REFC, "R8", "ref busy not extended", n, REFC);
      chk(ref_pos_o == 1'b1, "R8", "ref polarity kept", ref_pos_o, 1);

      // R9 unmapped address write
      wr(8'h10, 16'hFFFF);
      @(negedge clk);
      chk(status_o == 16'h0, "R9", "status after unmapped write", status_o, 0);
      chk(dac_cs_n_o == '1, "R9", "chip selects after unmapped write", dac_cs_n_o, 4'hF);
      repeat (40) @(negedge clk);

      chk(exp_q.size() == 0, "R2", "frames still expected", exp_q.size(), 0);
      chk(frames_seen == frames_exp, "R2", "frame count", frames_seen, frames_exp);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule